// File: doc/BRIEF.md
# Output release and mute sequencer

This block decides when the serial data output of an audio converter may carry real samples. After the power-on condition clears, it holds the converter core in reset for a fixed number of system clocks. It then keeps the output forced to zero until a fixed number of frames has gone by. Frames are counted on a frame-rate enable supplied by the clock detector.

An active-low power-down pin is brought into the system clock domain and filtered against short glitches. Once it is recognised, the block holds the core in reset and turns the data output driver off. Releasing the pin restarts the whole release sequence. The block also responds to loss-of-sync and resync events from the sync monitor. After a loss, the output keeps its current data until the next frame boundary. From there it is forced to zero until resync arrives, and it stays at zero for a further fixed number of frames after that.

Top module: `mute_seq`

## Requirements
- R1: While `por_i` is high, `core_rst_o`, `mute_o` and `dout_en_o` are all 1, with no clock edge needed.
- R2: After `por_i` falls, `core_rst_o` stays 1 for exactly RST_CYCLES (default 1024) rising clock edges and is 0 after the RST_CYCLES-th edge.
- R3: After `core_rst_o` clears, `mute_o` stays 1 until SETTLE_FRAMES (default 4480) frame ticks have been sampled. It clears right after the edge that samples the last of these ticks. Ticks seen while `core_rst_o` is 1 are not counted.
- R4: `mute_o` is 1 whenever `core_rst_o` is 1.
- R5: When the synchronized power-down pin has been low for PDN_MIN_CYCLES (default 4) consecutive clocks, `dout_en_o` goes to 0, and `core_rst_o` and `mute_o` go to 1. A 4-clock low pulse on `pdn_n_i` is enough.
- R6: A low pulse on `pdn_n_i` shorter than PDN_MIN_CYCLES clocks is ignored. Running output stays enabled and unmuted.
- R7: Release of power-down restarts the full sequence: `dout_en_o` returns to 1, then R2 and R3 apply again.
- R8: A `sync_lost_i` pulse during normal output leaves `mute_o` at 0 until the next frame tick is sampled. `mute_o` is 1 right after that edge.
- R9: Once muted by a sync loss, `mute_o` stays 1 regardless of frame ticks until `resync_i` pulses. It clears after exactly RESYNC_FRAMES (default 32) further frame ticks.
- R10: A `sync_lost_i` pulse during the post-resync count mutes again. A new resync then needs the full RESYNC_FRAMES ticks.
- R11: `sync_lost_i` and `resync_i` pulses during the power-on settle interval do not change when `mute_o` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on condition, high while supply is not yet valid (asynchronous) |
| pdn_n_i | input | 1 | Power-down pin, active low, asynchronous |
| frame_tick_i | input | 1 | One-cycle frame-rate enable from the clock detector |
| sync_lost_i | input | 1 | One-cycle pulse: frame clock lost sync with the system clock |
| resync_i | input | 1 | One-cycle pulse: sync re-established |
| core_rst_o | output | 1 | Reset for the converter core |
| mute_o | output | 1 | Force output samples to zero |
| dout_en_o | output | 1 | Data output driver enable |

## Verification
The interval counter is shared by all phases. If it were left stale or started at the wrong value on entry to a phase, `core_rst_o` or `mute_o` would release early or late by a countable number of edges or frame ticks. The bench therefore samples on both sides of each release boundary. A wrong state after a sync event shows up within one frame tick as a mute that is missing or stuck. A power-down filter with the wrong threshold shows up within a handful of clocks on `dout_en_o`, which is why the bench uses pulses of exactly one below and exactly at the threshold.

// File: rtl/mute_seq_pkg.sv
package mute_seq_pkg;

    typedef enum logic [2:0] {
        SQ_RESET  = 3'd0,
        SQ_SETTLE = 3'd1,
        SQ_RUN    = 3'd2,
        SQ_WAITF  = 3'd3,
        SQ_LOST   = 3'd4,
        SQ_RECOV  = 3'd5,
        SQ_DOWN   = 3'd6
    } seq_state_e;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/mute_seq_pdn_filt.sv
module mute_seq_pdn_filt #(
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned PDN_MIN_CYCLES = 4
) (
    input  logic clk,
    input  logic por_i,
    input  logic pdn_n_i,
    output logic pdn_active_o
);
    localparam int unsigned LW = $clog2(PDN_MIN_CYCLES + 1);
    localparam logic [LW-1:0] LOW_TOP = LW'(PDN_MIN_CYCLES - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [LW-1:0]          low_cnt;
    } filt_t;

    filt_t filt_d, filt_q;
    logic  pin_low;

    assign pin_low = ~filt_q.sync[SYNC_STAGES-1];

    always_comb begin
        filt_d      = filt_q;
        filt_d.sync = {filt_q.sync[SYNC_STAGES-2:0], pdn_n_i};
        if (!pin_low) begin
            filt_d.low_cnt = '0;
        end else if (filt_q.low_cnt != LOW_TOP) begin
            filt_d.low_cnt = filt_q.low_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            filt_q.sync    <= '1;
            filt_q.low_cnt <= '0;
        end else begin
            filt_q <= filt_d;
        end
    end

    assign pdn_active_o = pin_low && (filt_q.low_cnt == LOW_TOP);

    // R6
    low_cnt_bound_chk: assert property (@(posedge clk) disable iff (por_i)
        filt_q.low_cnt <= LOW_TOP);

endmodule

// File: rtl/mute_seq_fsm.sv
module mute_seq_fsm
    import mute_seq_pkg::*;
#(
    parameter int unsigned RST_CYCLES    = 1024,
    parameter int unsigned SETTLE_FRAMES = 4480,
    parameter int unsigned RESYNC_FRAMES = 32
) (
    input  logic clk,
    input  logic por_i,
    input  logic pdn_active_i,
    input  logic frame_tick_i,
    input  logic sync_lost_i,
    input  logic resync_i,
    output logic core_rst_o,
    output logic mute_o,
    output logic dout_en_o
);
    localparam int unsigned CMAX = max3(RST_CYCLES, SETTLE_FRAMES, RESYNC_FRAMES);
    localparam int unsigned CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] RST_LAST    = CW'(RST_CYCLES - 1);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_FRAMES - 1);
    localparam logic [CW-1:0] RECOV_LAST  = CW'(RESYNC_FRAMES - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (pdn_active_i) begin
            seq_d.state = SQ_DOWN;
            seq_d.cnt   = '0;
        end else begin
            case (seq_q.state)
                SQ_RESET: begin
                    if (seq_q.cnt == RST_LAST) begin
                        seq_d.state = SQ_SETTLE;
                        seq_d.cnt   = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
                SQ_SETTLE: begin
                    if (frame_tick_i) begin
                        if (seq_q.cnt == SETTLE_LAST) begin
                            seq_d.state = SQ_RUN;
                            seq_d.cnt   = '0;
                        end else begin
                            seq_d.cnt = seq_q.cnt + 1'b1;
                        end
                    end
                end
                SQ_RUN: begin
                    if (sync_lost_i) seq_d.state = SQ_WAITF;
                end
                SQ_WAITF: begin
                    if (frame_tick_i) seq_d.state = SQ_LOST;
                end
                SQ_LOST: begin
                    if (resync_i) begin
                        seq_d.state = SQ_RECOV;
                        seq_d.cnt   = '0;
                    end
                end
                SQ_RECOV: begin
                    if (sync_lost_i) begin
                        seq_d.state = SQ_LOST;
                        seq_d.cnt   = '0;
                    end else if (frame_tick_i) begin
                        if (seq_q.cnt == RECOV_LAST) begin
                            seq_d.state = SQ_RUN;
                            seq_d.cnt   = '0;
                        end else begin
                            seq_d.cnt = seq_q.cnt + 1'b1;
                        end
                    end
                end
                SQ_DOWN: begin
                    seq_d.state = SQ_RESET;
                    seq_d.cnt   = '0;
                end
                default: begin
                    seq_d.state = SQ_RESET;
                    seq_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            seq_q.state <= SQ_RESET;
            seq_q.cnt   <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign core_rst_o = (seq_q.state == SQ_RESET) || (seq_q.state == SQ_DOWN);
    assign mute_o     = (seq_q.state != SQ_RUN) && (seq_q.state != SQ_WAITF);
    assign dout_en_o  = (seq_q.state != SQ_DOWN);

    // R2
    rst_len_chk: assert property (@(posedge clk) disable iff (por_i)
        $fell(core_rst_o) |-> ($past(seq_q.cnt) == RST_LAST));

    // R3
    unmute_on_tick_chk: assert property (@(posedge clk) disable iff (por_i)
        $fell(mute_o) |-> $past(frame_tick_i));

    // R4
    rst_keeps_mute_chk: assert property (@(posedge clk) disable iff (por_i)
        $fell(mute_o) |-> !core_rst_o);

    // R5
    pdn_disables_chk: assert property (@(posedge clk) disable iff (por_i)
        pdn_active_i |=> (!dout_en_o && core_rst_o));

    // R7
    pdn_restart_chk: assert property (@(posedge clk) disable iff (por_i)
        $rose(dout_en_o) |-> (core_rst_o && seq_q.cnt == '0));

    // R9
    lost_hold_chk: assert property (@(posedge clk) disable iff (por_i)
        (seq_q.state == SQ_LOST && !resync_i && !pdn_active_i) |=> mute_o);

endmodule

// File: rtl/mute_seq.sv
module mute_seq #(
    parameter int unsigned RST_CYCLES     = 1024,
    parameter int unsigned SETTLE_FRAMES  = 4480,
    parameter int unsigned RESYNC_FRAMES  = 32,
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned PDN_MIN_CYCLES = 4
) (
    input  logic clk,
    input  logic por_i,
    input  logic pdn_n_i,
    input  logic frame_tick_i,
    input  logic sync_lost_i,
    input  logic resync_i,
    output logic core_rst_o,
    output logic mute_o,
    output logic dout_en_o
);
    logic pdn_active;

    mute_seq_pdn_filt #(
        .SYNC_STAGES    (SYNC_STAGES),
        .PDN_MIN_CYCLES (PDN_MIN_CYCLES)
    ) u_pdn_filt (
        .clk          (clk),
        .por_i        (por_i),
        .pdn_n_i      (pdn_n_i),
        .pdn_active_o (pdn_active)
    );

    mute_seq_fsm #(
        .RST_CYCLES    (RST_CYCLES),
        .SETTLE_FRAMES (SETTLE_FRAMES),
        .RESYNC_FRAMES (RESYNC_FRAMES)
    ) u_fsm (
        .clk          (clk),
        .por_i        (por_i),
        .pdn_active_i (pdn_active),
        .frame_tick_i (frame_tick_i),
        .sync_lost_i  (sync_lost_i),
        .resync_i     (resync_i),
        .core_rst_o   (core_rst_o),
        .mute_o       (mute_o),
        .dout_en_o    (dout_en_o)
    );

endmodule

// File: tb/mute_seq_bench.sv
`timescale 1ns/100ps
module mute_seq_bench;
    localparam int RST_N    = 1024;
    localparam int SETTLE_N = 4480;
    localparam int RESYNC_N = 32;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic pdn_n = 1'b1;
    logic ftick = 1'b0;
    logic slost = 1'b0;
    logic rsync = 1'b0;
    logic core_rst, mute, dout_en;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    mute_seq u_mute_seq (
        .clk          (clk),
        .por_i        (por),
        .pdn_n_i      (pdn_n),
        .frame_tick_i (ftick),
        .sync_lost_i  (slost),
        .resync_i     (rsync),
        .core_rst_o   (core_rst),
        .mute_o       (mute),
        .dout_en_o    (dout_en)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic pulse_frame();
        ftick = 1'b1;
        @(negedge clk);
        ftick = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_sig(input int which);
        if (which == 0) slost = 1'b1; else rsync = 1'b1;
        @(negedge clk);
        slost = 1'b0;
        rsync = 1'b0;
        @(negedge clk);
    endtask

    // Called at the negedge where reset counting starts (cnt 0 held).
    task automatic release_check(input string tag, input bit noise);
        for (int i = 1; i < RST_N; i++) begin
            if (i >= 10 && i < 14) ftick = 1'b1; else ftick = 1'b0;   // R3: ignored
            @(negedge clk);
        end
        ftick = 1'b0;
        chk({tag, " R2 core_rst before release"}, core_rst, 1'b1);
        chk({tag, " R4 mute during reset"}, mute, 1'b1);
        @(negedge clk);
        chk({tag, " R2 core_rst after release"}, core_rst, 1'b0);
        for (int f = 1; f <= SETTLE_N; f++) begin
            if (noise && f == 100) pulse_sig(0);   // R11
            if (noise && f == 200) pulse_sig(1);   // R11
            pulse_frame();
            if (f == SETTLE_N - 1) chk({tag, " R3 R11 mute one tick early"}, mute, 1'b1);
        end
        chk({tag, " R3 R11 mute released"}, mute, 1'b0);
        chk({tag, " R3 dout_en on"}, dout_en, 1'b1);
    endtask

    task automatic t_por();
        repeat (3) @(negedge clk);
        ftick = 1'b1;
        @(negedge clk);
        ftick = 1'b0;
        chk("R1 core_rst in por", core_rst, 1'b1);
        chk("R1 mute in por", mute, 1'b1);
        chk("R1 dout_en in por", dout_en, 1'b1);
        por = 1'b0;
        release_check("por", 1'b1);
    endtask

    task automatic t_sync();
        pulse_sig(0);
        repeat (6) @(negedge clk);
        chk("R8 no mute before frame tick", mute, 1'b0);
        ftick = 1'b1;
        @(negedge clk);
        ftick = 1'b0;
        chk("R8 mute after frame tick", mute, 1'b1);
        repeat (5) pulse_frame();
        repeat (10) @(negedge clk);
        chk("R9 mute held without resync", mute, 1'b1);
        pulse_sig(1);
        for (int f = 1; f <= 10; f++) pulse_frame();
        pulse_sig(0);                               // R10
        for (int f = 1; f <= 40; f++) pulse_frame();
        chk("R10 mute held after second loss", mute, 1'b1);
        pulse_sig(1);
        for (int f = 1; f <= RESYNC_N; f++) begin
            pulse_frame();
            if (f == RESYNC_N - 1) chk("R9 R10 mute one tick early", mute, 1'b1);
        end
        chk("R9 mute released after resync count", mute, 1'b0);
    endtask

    task automatic t_pdn();
        bit seen;
        pdn_n = 1'b0;
        repeat (3) @(negedge clk);
        pdn_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R6 short pulse dout_en", dout_en, 1'b1);
        chk("R6 short pulse mute", mute, 1'b0);
        chk("R6 short pulse core_rst", core_rst, 1'b0);
        pdn_n = 1'b0;
        repeat (4) @(negedge clk);
        pdn_n = 1'b1;
        seen = 1'b0;
        for (int k = 0; k < 10 && !seen; k++) begin
            @(negedge clk);
            if (!dout_en) seen = 1'b1;
        end
        chk("R5 dout_en off", seen ? 1'b0 : 1'b1, 1'b0);
        chk("R5 core_rst in power-down", core_rst, 1'b1);
        chk("R5 mute in power-down", mute, 1'b1);
        seen = 1'b0;
        for (int k = 0; k < 10 && !seen; k++) begin
            @(negedge clk);
            if (dout_en) seen = 1'b1;
        end
        chk("R7 dout_en back", dout_en, 1'b1);
        release_check("pdn R7", 1'b0);
    endtask

    task automatic t_por_again();
        @(negedge clk);
        por = 1'b1;
        #1;
        chk("R1 async core_rst", core_rst, 1'b1);
        chk("R1 async mute", mute, 1'b1);
        chk("R1 async dout_en", dout_en, 1'b1);
    endtask

    initial begin
        t_por();
        t_sync();
        t_pdn();
        t_por_again();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule